// File: doc/BRIEF.md
# Ethernet Transmit Error Retry Controller

This block sits beside a MAC transmit engine and acts on the status vector the engine reports when it finishes sending a frame. The vector holds nine error flags. Each flag sets its own sticky status bit. The status bits are split into a low half and a high half, and the host clears them by writing ones. From per-error enable bits, the block decides whether the engine should send the same frame again. On a no-carrier report it can instead ask for the pending transmit queue to be flushed.

The block answers every completed frame with exactly one single-cycle pulse, one clock after the status is presented. The pulse is one of three: resend the frame, flush the queue, or finish the frame and move on. A retry counter caps automatic resends of one frame at the parameter `MAX_RETRY` (default 3). When the cap is reached, the frame is dropped and a retry-exhausted bit is set.

Top module: `txRetryCtrl`

## Requirements
- R1: When `statValid` is high, each set bit of `statFlags[7:0]` sets the same bit of `statusLo` on the next clock edge, and the bit stays set. The bit positions are: 0 jabber timeout, 1 loss of carrier, 2 excessive deferral, 3 late collision, 4 excessive collisions, 5 underrun, 6 deferred, 7 collision.
- R2: `statFlags[8]` (heartbeat fail) sets `statusHi[0]` in the same way. `statusHi[1]` is the sticky retry-exhausted bit.
- R3: A clear strobe (`clrLoStb` or `clrHiStb`) clears every status bit whose mask bit is 1. Bits whose mask bit is 0 are unaffected.
- R4: If a status bit is set and cleared in the same cycle, the set wins.
- R5: A completed frame with any error whose bit in `retryEnable` is 1 produces `retryReq`, subject to R6 and R8. Deferred (bit 6) and heartbeat fail (bit 8) have their own enables like the others. Errors whose enable bit is 0 give `frameDoneOk`.
- R6: If `statFlags[1]` and `flushOnNoCarrier` are both set, the block produces `flushReq` and no retry, even when a retry is enabled.
- R7: Loss of carrier with `flushOnNoCarrier` low is treated like any other error, according to its retry enable.
- R8: After `MAX_RETRY` consecutive retries of one frame, the next retry-worthy completion gives `frameDoneOk` instead of a retry and sets `statusHi[1]`.
- R9: For each cycle with `statValid` high, exactly one of `retryReq`, `flushReq` and `frameDoneOk` is high on the next cycle, for one cycle only. With `statValid` low, none of them rises and the flags are ignored.
- R10: After reset, all pulses and all status bits are 0.
- R11: A done or flush outcome restarts the retry count, so the next frame again gets `MAX_RETRY` retries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| statValid | input | 1 | Frame completion status is present this cycle |
| statFlags | input | 9 | Error flags of the completed frame |
| retryEnable | input | 9 | Per-error retry enable, same bit positions as `statFlags` |
| flushOnNoCarrier | input | 1 | Flush the queue instead of acting further on loss of carrier |
| clrLoStb | input | 1 | Write strobe for clearing the low status half |
| clrLoMask | input | 8 | Write-one-to-clear mask for `statusLo` |
| clrHiStb | input | 1 | Write strobe for clearing the high status half |
| clrHiMask | input | 2 | Write-one-to-clear mask for `statusHi` |
| statusLo | output | 8 | Sticky error bits 0 to 7 |
| statusHi | output | 2 | Sticky heartbeat fail (bit 0) and retry exhausted (bit 1) |
| retryReq | output | 1 | Pulse: resend the same frame |
| flushReq | output | 1 | Pulse: flush the pending transmit queue |
| frameDoneOk | output | 1 | Pulse: frame finished, move to the next one |

## Verification
If the retry counter holds a wrong value, the pulses go wrong: a frame is resent one time too many or too few before the retry-exhausted bit rises. This only shows after a run of up to `MAX_RETRY`+1 completions of the same frame, which is why the bench sends such runs back to back and also checks the first frame after a flush. A wrong decision shows on the pulse outputs one cycle after `statValid`. Sticky state that is cleared or set wrongly shows on `statusLo` and `statusHi` at that same edge.

// File: rtl/txRetryPkg.sv
package txRetryPkg;
  localparam int NUM_ERR       = 9;
  localparam int IDX_JABBER    = 0;
  localparam int IDX_NOCARRIER = 1;
  localparam int IDX_EXDEFER   = 2;
  localparam int IDX_LATECOLL  = 3;
  localparam int IDX_EXCOLL    = 4;
  localparam int IDX_UNDERRUN  = 5;
  localparam int IDX_DEFERRED  = 6;
  localparam int IDX_COLLISION = 7;
  localparam int IDX_HEARTBEAT = 8;

  typedef enum logic [1:0] {
    ACT_DONE  = 2'd0,
    ACT_RETRY = 2'd1,
    ACT_FLUSH = 2'd2,
    ACT_DROP  = 2'd3
  } action_t;

  typedef struct packed {
    logic stickyLoad;
    logic setExhaust;
    logic cntInc;
    logic cntClr;
  } ctlStrobe_t;
endpackage

// File: rtl/txRetryData.sv
module txRetryData
  import txRetryPkg::*;
#(
  parameter int MAX_RETRY = 3,
  parameter int LO_W      = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strb,
  input  logic [NUM_ERR-1:0]   statFlags,
  input  logic                 clrLoStb,
  input  logic [LO_W-1:0]      clrLoMask,
  input  logic                 clrHiStb,
  input  logic [NUM_ERR-LO_W:0] clrHiMask,
  output logic [LO_W-1:0]      statusLo,
  output logic [NUM_ERR-LO_W:0] statusHi,
  output logic                 cntAtMax
);
  localparam int STAT_W = NUM_ERR + 1;
  localparam int HI_W   = STAT_W - LO_W;
  localparam int CNT_W  = $clog2(MAX_RETRY + 1);

  logic [STAT_W-1:0] statReg;
  logic [STAT_W-1:0] setVec;
  logic [STAT_W-1:0] clrVec;
  logic [CNT_W-1:0]  retryCnt;

  assign setVec = {strb.setExhaust, statFlags & {NUM_ERR{strb.stickyLoad}}};
  assign clrVec = {clrHiMask & {HI_W{clrHiStb}}, clrLoMask & {LO_W{clrLoStb}}};

  for (genvar b = 0; b < STAT_W; b++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rstN)          statReg[b] <= 1'b0;
      else if (setVec[b]) statReg[b] <= 1'b1;
      else if (clrVec[b]) statReg[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            retryCnt <= '0;
    else if (strb.cntClr) retryCnt <= '0;
    else if (strb.cntInc) retryCnt <= retryCnt + 1'b1;
  end

  assign cntAtMax = (32'(retryCnt) >= MAX_RETRY);
  assign statusLo = statReg[LO_W-1:0];
  assign statusHi = statReg[STAT_W-1:LO_W];
endmodule

// File: rtl/txRetryCtl.sv
module txRetryCtl
  import txRetryPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               statValid,
  input  logic [NUM_ERR-1:0] statFlags,
  input  logic [NUM_ERR-1:0] retryEnable,
  input  logic               flushOnNoCarrier,
  input  logic               cntAtMax,
  output ctlStrobe_t         strb,
  output logic               retryReq,
  output logic               flushReq,
  output logic               frameDoneOk
);
  action_t act;
  logic    wantFlush;
  logic    wantRetry;

  assign wantFlush = statFlags[IDX_NOCARRIER] & flushOnNoCarrier;
  assign wantRetry = |(statFlags & retryEnable);

  always_comb begin
    if (wantFlush)      act = ACT_FLUSH;
    else if (!wantRetry) act = ACT_DONE;
    else if (cntAtMax)  act = ACT_DROP;
    else                act = ACT_RETRY;
  end

  always_comb begin
    strb            = '0;
    strb.stickyLoad = statValid;
    strb.setExhaust = statValid && (act == ACT_DROP);
    strb.cntInc     = statValid && (act == ACT_RETRY);
    strb.cntClr     = statValid && (act != ACT_RETRY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retryReq    <= 1'b0;
      flushReq    <= 1'b0;
      frameDoneOk <= 1'b0;
    end else begin
      retryReq    <= statValid && (act == ACT_RETRY);
      flushReq    <= statValid && (act == ACT_FLUSH);
      frameDoneOk <= statValid && ((act == ACT_DONE) || (act == ACT_DROP));
    end
  end
endmodule

// File: rtl/txRetryCtrl.sv
module txRetryCtrl
  import txRetryPkg::*;
#(
  parameter int MAX_RETRY = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               statValid,
  input  logic [8:0]         statFlags,
  input  logic [8:0]         retryEnable,
  input  logic               flushOnNoCarrier,
  input  logic               clrLoStb,
  input  logic [7:0]         clrLoMask,
  input  logic               clrHiStb,
  input  logic [1:0]         clrHiMask,
  output logic [7:0]         statusLo,
  output logic [1:0]         statusHi,
  output logic               retryReq,
  output logic               flushReq,
  output logic               frameDoneOk
);
  ctlStrobe_t strb;
  logic       cntAtMax;

  txRetryCtl u_ctl (
    .clk(clk), .rstN(rstN), .statValid(statValid), .statFlags(statFlags),
    .retryEnable(retryEnable), .flushOnNoCarrier(flushOnNoCarrier),
    .cntAtMax(cntAtMax), .strb(strb), .retryReq(retryReq),
    .flushReq(flushReq), .frameDoneOk(frameDoneOk)
  );

  txRetryData #(.MAX_RETRY(MAX_RETRY), .LO_W(8)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .statFlags(statFlags),
    .clrLoStb(clrLoStb), .clrLoMask(clrLoMask), .clrHiStb(clrHiStb),
    .clrHiMask(clrHiMask), .statusLo(statusLo), .statusHi(statusHi),
    .cntAtMax(cntAtMax)
  );
endmodule

// File: rtl/txRetryChecker.sv
module txRetryChecker (
  input logic       clk,
  input logic       rstN,
  input logic       statValid,
  input logic [8:0] statFlags,
  input logic [8:0] retryEnable,
  input logic       flushOnNoCarrier,
  input logic       clrLoStb,
  input logic [7:0] clrLoMask,
  input logic [7:0] statusLo,
  input logic [1:0] statusHi,
  input logic       retryReq,
  input logic       flushReq,
  input logic       frameDoneOk
);
  // R9: exactly one outcome pulse per completed frame
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rstN)
    statValid |=> ($countones({retryReq, flushReq, frameDoneOk}) == 1));

  // R9: no outcome without a completion
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rstN)
    !statValid |=> ({retryReq, flushReq, frameDoneOk} == 3'b000));

  // R1: reported flags are recorded
  p_sticky_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    statValid |=> ((statusLo & $past(statFlags[7:0])) == $past(statFlags[7:0])));

  // R4: set beats a simultaneous clear
  p_set_over_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && clrLoStb) |=> ((statusLo & $past(statFlags[7:0])) == $past(statFlags[7:0])));

  // R3: masked bits clear when no new error arrives
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clrLoStb && !statValid) |=> ((statusLo & $past(clrLoMask)) == 8'h00));

  // R6: flush on no carrier when enabled
  p_flush_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && statFlags[1] && flushOnNoCarrier) |=> flushReq);

  // R5: no retry without an enabled error
  p_no_retry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statValid && ((statFlags & retryEnable) == 9'h000)) |=> !retryReq);

  // R8: exhaustion is reported together with the frame being finished
  p_exhaust_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusHi[1]) |-> frameDoneOk);
endmodule

bind txRetryCtrl txRetryChecker u_chk (
  .clk(clk), .rstN(rstN), .statValid(statValid), .statFlags(statFlags),
  .retryEnable(retryEnable), .flushOnNoCarrier(flushOnNoCarrier),
  .clrLoStb(clrLoStb), .clrLoMask(clrLoMask), .statusLo(statusLo),
  .statusHi(statusHi), .retryReq(retryReq), .flushReq(flushReq),
  .frameDoneOk(frameDoneOk)
);

// File: tb/sim_txRetryCtrl.sv
module sim_txRetryCtrl;
  localparam int MAXR = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       statValid = 1'b0;
  logic [8:0] statFlags = '0;
  logic [8:0] retryEnable = '0;
  logic       flushOnNoCarrier = 1'b0;
  logic       clrLoStb = 1'b0;
  logic [7:0] clrLoMask = '0;
  logic       clrHiStb = 1'b0;
  logic [1:0] clrHiMask = '0;
  logic [7:0] statusLo;
  logic [1:0] statusHi;
  logic       retryReq, flushReq, frameDoneOk;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  txRetryCtrl #(.MAX_RETRY(MAXR)) u0 (
    .clk(clk), .rstN(rstN), .statValid(statValid), .statFlags(statFlags),
    .retryEnable(retryEnable), .flushOnNoCarrier(flushOnNoCarrier),
    .clrLoStb(clrLoStb), .clrLoMask(clrLoMask), .clrHiStb(clrHiStb),
    .clrHiMask(clrHiMask), .statusLo(statusLo), .statusHi(statusHi),
    .retryReq(retryReq), .flushReq(flushReq), .frameDoneOk(frameDoneOk)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // outcome code: {retry, flush, done}
  task automatic sendFrame(logic [8:0] flags, logic [2:0] expOut, string req);
    @(negedge clk);
    statValid = 1'b1;
    statFlags = flags;
    @(negedge clk);
    statValid = 1'b0;
    statFlags = '0;
    check(req, {retryReq, flushReq, frameDoneOk}, expOut);
    @(negedge clk);
    check({req, " R9 pulse width"}, {retryReq, flushReq, frameDoneOk}, 0);
  endtask

  task automatic clearAll();
    @(negedge clk);
    clrLoStb = 1'b1; clrLoMask = 8'hFF; clrHiStb = 1'b1; clrHiMask = 2'b11;
    @(negedge clk);
    clrLoStb = 1'b0; clrLoMask = '0; clrHiStb = 1'b0; clrHiMask = '0;
  endtask

  task automatic testReset();
    check("R10 pulses", {retryReq, flushReq, frameDoneOk}, 0);
    check("R10 statusLo", statusLo, 0);
    check("R10 statusHi", statusHi, 0);
  endtask

  task automatic testStickyEach();
    retryEnable = '0;
    for (int b = 0; b < 9; b++) begin
      sendFrame(9'(1) << b, 3'b001, "R5 disabled error gives done");
      if (b < 8) begin
        check("R1 sticky bit", statusLo, 1 << b);
        check("R2 hi clear", statusHi, 0);
      end else begin
        check("R2 heartbeat bit", statusHi, 1);
        check("R1 lo untouched", statusLo, 0);
      end
      clearAll();
      check("R3 cleared lo", statusLo, 0);
      check("R3 cleared hi", statusHi, 0);
    end
  endtask

  task automatic testSeparateEnables();
    retryEnable = 9'h040; // deferred only
    sendFrame(9'h040, 3'b100, "R5 deferred retry");
    sendFrame(9'h080, 3'b001, "R5 collision not enabled");
    retryEnable = 9'h100; // heartbeat only
    sendFrame(9'h100, 3'b100, "R5 heartbeat retry");
    sendFrame(9'h040, 3'b001, "R5 deferred disabled");
    sendFrame(9'h000, 3'b001, "R11 clean frame");
    clearAll();
  endtask

  task automatic testRetryLimit();
    retryEnable = 9'h001;
    for (int i = 0; i < MAXR; i++) sendFrame(9'h001, 3'b100, "R8 retry within limit");
    check("R8 not yet exhausted", statusHi[1], 0);
    sendFrame(9'h001, 3'b001, "R8 drop at limit");
    check("R8 exhausted bit", statusHi[1], 1);
    sendFrame(9'h001, 3'b100, "R11 count restarts after drop");
    sendFrame(9'h000, 3'b001, "R11 clean frame");
    @(negedge clk);
    clrHiStb = 1'b1; clrHiMask = 2'b01;
    @(negedge clk);
    clrHiStb = 1'b0; clrHiMask = '0;
    check("R3 zero mask bit kept", statusHi, 2'b10);
    clearAll();
  endtask

  task automatic testFlush();
    retryEnable = 9'h003;
    flushOnNoCarrier = 1'b1;
    sendFrame(9'h001, 3'b100, "R11 first retry");
    sendFrame(9'h001, 3'b100, "R11 second retry");
    sendFrame(9'h003, 3'b010, "R6 flush wins over retry");
    for (int i = 0; i < MAXR; i++) sendFrame(9'h001, 3'b100, "R11 full retries after flush");
    sendFrame(9'h001, 3'b001, "R8 drop after flush run");
    flushOnNoCarrier = 1'b0;
    sendFrame(9'h002, 3'b100, "R7 no carrier retried when flush off");
    retryEnable = 9'h000;
    sendFrame(9'h002, 3'b001, "R7 no carrier done when disabled");
    check("R1 no carrier bit", statusLo[1], 1);
    clearAll();
  endtask

  task automatic testSetOverClear();
    retryEnable = '0;
    sendFrame(9'h001, 3'b001, "R1 jabber done");
    @(negedge clk);
    statValid = 1'b1; statFlags = 9'h080;
    clrLoStb = 1'b1; clrLoMask = 8'h81;
    @(negedge clk);
    statValid = 1'b0; statFlags = '0; clrLoStb = 1'b0; clrLoMask = '0;
    check("R4 set beats clear", statusLo, 8'h80);
    check("R9 outcome with clear", {retryReq, flushReq, frameDoneOk}, 1);
    clearAll();
  endtask

  task automatic testIgnoredFlags();
    retryEnable = 9'h1FF;
    flushOnNoCarrier = 1'b1;
    @(negedge clk);
    statFlags = 9'h1FF;
    @(negedge clk);
    check("R9 no pulse without valid", {retryReq, flushReq, frameDoneOk}, 0);
    @(negedge clk);
    statFlags = '0;
    check("R9 status untouched lo", statusLo, 0);
    check("R9 status untouched hi", statusHi, 0);
    flushOnNoCarrier = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStickyEach();
    testSeparateEnables();
    testRetryLimit();
    testFlush();
    testSetOverClear();
    testIgnoredFlags();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end
endmodule